// File: doc/BRIEF.md
# Latched 64-bit System Time Counter

This block keeps the local time of a precision time-sync node as a 64-bit up-counter. A 32-bit fractional accumulator adds a host-programmed addend on every clock. Each time that addition carries out of the top bit, the counter advances by one. The ratio of the addend to 2^32 therefore sets the tick rate. An addend of zero stops the count.

The host reaches the counter through a 16-bit register bus with byte offsets. Because 64 bits do not fit in one bus word, access is made coherent in two ways:

- **Reads.** Reading the lowest time word also captures the upper 48 bits of the live count in a holding latch. Reads of the three upper words then return that snapshot.
- **Writes.** Writes to the three lower words only fill staging registers. Writing the top word loads the whole 64-bit value in one clock.

Top module: `sys_time_counter`

## Requirements
- R1: After synchronous reset, the following are zero: the counter, the read latch, the staging words, the addend, the accumulator, `rd_data` and `rd_valid`.
- R2: Every clock, the accumulator adds the addend modulo 2^32. The counter advances by exactly one in each cycle where that addition carries out. With an addend of zero, the counter holds its value.
- R3: The counter counts upward across all 64 bits. A carry out of one 16-bit word propagates into the next word.
- R4: A read of time word 0 (offset 0x0) returns bits 15:0 of the live count. The same read captures bits 63:16 of the live count into a latch. Reads of offsets 0x2, 0x4 and 0x6 return latch bits 31:16, 47:32 and 63:48, even if the count has been reloaded since the capture.
- R5: Writes to offsets 0x0, 0x2 and 0x4 go to staging registers only. They leave the running counter unchanged.
- R6: A write to offset 0x6 loads the counter in one cycle. The loaded value takes bits 63:48 from the written data and bits 47:0 from the three staged words.
- R7: If a top-word load and an accumulator carry fall in the same cycle, the loaded value is kept and that increment is dropped.
- R8: The addend is split across two words: offset 0x8 holds bits 15:0 and offset 0xA holds bits 31:16. Both words are writable and readable. A read strobe sampled at a clock edge makes `rd_data` and `rd_valid` valid from that edge until the next one.
- R9: Outside a load, the counter never decreases. From one cycle to the next it either holds or rises by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | High for one cycle after a read strobe |

## Verification
The assertions check the following on every cycle:

- The counter holds when there is no carry and steps by one when there is.
- A top-word load lands exactly and suppresses any increment in the same cycle.
- The latch captures the live upper bits on a low-word read and stays stable otherwise.
- `rd_valid` follows the read strobe.

Only the bench's scenarios can show the following:

- The staged words end up in the right fields of the loaded value.
- Upper-word reads return the old snapshot after a reload.
- The tick count over a fixed window with an addend of one half yields the expected carry across the 32-bit word boundary.
- The addend words read back correctly.

// File: rtl/sys_time_pkg.sv
package sys_time_pkg;

    localparam int WORD_W_DEF = 16;
    localparam int TIME_W_DEF = 64;
    localparam int ACC_W_DEF  = 32;
    localparam int ADDR_W_DEF = 4;

    // Register class selected by the bus decoder
    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_TIME   = 2'd1,
        K_ADDEND = 2'd2
    } reg_kind_e;

    // Number of bus words needed to cover a field
    function automatic int words_of(input int field_w, input int word_w);
        return (field_w + word_w - 1) / word_w;
    endfunction

    // Index width for a slot count, at least one bit
    function automatic int idx_bits(input int slots);
        return (slots <= 2) ? 1 : $clog2(slots);
    endfunction

endpackage

// File: rtl/sys_time_regbus.sv
module sys_time_regbus
    import sys_time_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int NUM_WORDS = 4,
    parameter int ADD_WORDS = 2,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        int slot;
        slot = int'(addr[ADDR_W-1:1]);
        kind = K_NONE;
        idx  = '0;
        if (!addr[0]) begin
            if (slot < NUM_WORDS) begin
                kind = K_TIME;
                idx  = IDX_W'(slot);
            end else if (slot < NUM_WORDS + ADD_WORDS) begin
                kind = K_ADDEND;
                idx  = IDX_W'(slot - NUM_WORDS);
            end
        end
    end

endmodule

// File: rtl/sys_time_accum.sv
module sys_time_accum
    import sys_time_pkg::*;
#(
    parameter int ACC_W     = ACC_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int ADD_WORDS = 2,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addend,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ACC_W-1:0]  addend,
    output logic              carry
);

    localparam int PAD_W = ADD_WORDS * WORD_W;

    logic [PAD_W-1:0] addend_words;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    genvar g;
    generate
        for (g = 0; g < ADD_WORDS; g++) begin : g_addend
            always_ff @(posedge clk) begin
                if (rst)
                    addend_words[g*WORD_W +: WORD_W] <= '0;
                else if (wr_addend && wr_idx == IDX_W'(g))
                    addend_words[g*WORD_W +: WORD_W] <= wr_data;
            end
        end
    endgenerate

    assign addend = addend_words[ACC_W-1:0];
    assign sum    = {1'b0, acc_q} + {1'b0, addend};
    assign carry  = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/sys_time_count.sv
module sys_time_count
    import sys_time_pkg::*;
#(
    parameter int TIME_W    = TIME_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_time,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              carry,
    output logic              load,
    output logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_q
);

    localparam int STAGE_N = NUM_WORDS - 1;
    localparam int LOW_W   = STAGE_N * WORD_W;

    logic [WORD_W-1:0] stage [STAGE_N];
    logic [LOW_W-1:0]  stage_flat;

    genvar g;
    generate
        for (g = 0; g < STAGE_N; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[g] <= '0;
                else if (wr_time && wr_idx == IDX_W'(g))
                    stage[g] <= wr_data;
            end
            assign stage_flat[g*WORD_W +: WORD_W] = stage[g];
        end
    endgenerate

    assign load     = wr_time && (wr_idx == IDX_W'(NUM_WORDS - 1));
    assign load_val = {wr_data, stage_flat};

    // Load outranks the increment in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (load)
            time_q <= load_val;
        else if (carry)
            time_q <= time_q + TIME_W'(1);
    end

endmodule

// File: rtl/sys_time_rdpath.sv
module sys_time_rdpath
    import sys_time_pkg::*;
#(
    parameter int TIME_W    = TIME_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int ACC_W     = ACC_W_DEF,
    parameter int NUM_WORDS = 4,
    parameter int ADD_WORDS = 2,
    parameter int IDX_W     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  reg_kind_e                kind,
    input  logic [IDX_W-1:0]         idx,
    input  logic [TIME_W-1:0]        time_q,
    input  logic [ACC_W-1:0]         addend,
    output logic                     rd_low,
    output logic [TIME_W-WORD_W-1:0] latch_q,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_valid
);

    localparam int UP_W  = TIME_W - WORD_W;
    localparam int PAD_W = ADD_WORDS * WORD_W;

    logic [PAD_W-1:0]  addend_pad;
    logic [WORD_W-1:0] sel_word;

    assign addend_pad = PAD_W'(addend);
    assign rd_low     = rd_en && (kind == K_TIME) && (idx == '0);

    always_comb begin
        sel_word = '0;
        if (kind == K_TIME) begin
            if (idx == '0)
                sel_word = time_q[WORD_W-1:0];
            for (int k = 1; k < NUM_WORDS; k++)
                if (idx == IDX_W'(k))
                    sel_word = latch_q[(k-1)*WORD_W +: WORD_W];
        end else if (kind == K_ADDEND) begin
            for (int k = 0; k < ADD_WORDS; k++)
                if (idx == IDX_W'(k))
                    sel_word = addend_pad[k*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= sel_word;
            if (rd_low)
                latch_q <= time_q[TIME_W-1:WORD_W];
        end
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, UP_W[0]};

endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter
    import sys_time_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int NUM_WORDS = words_of(TIME_W, WORD_W);
    localparam int ADD_WORDS = words_of(ACC_W, WORD_W);
    localparam int IDX_W     = idx_bits(NUM_WORDS);

    reg_kind_e                kind;
    logic [IDX_W-1:0]         idx;
    logic                     carry;
    logic [ACC_W-1:0]         addend;
    logic                     load;
    logic [TIME_W-1:0]        load_val;
    logic [TIME_W-1:0]        time_q;
    logic                     rd_low;
    logic [TIME_W-WORD_W-1:0] latch_q;

    sys_time_regbus #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
        .ADD_WORDS(ADD_WORDS), .IDX_W(IDX_W)
    ) i_regbus (
        .addr(addr), .kind(kind), .idx(idx)
    );

    sys_time_accum #(
        .ACC_W(ACC_W), .WORD_W(WORD_W),
        .ADD_WORDS(ADD_WORDS), .IDX_W(IDX_W)
    ) i_accum (
        .clk(clk), .rst(rst),
        .wr_addend(wr_en && kind == K_ADDEND),
        .wr_idx(idx), .wr_data(wr_data),
        .addend(addend), .carry(carry)
    );

    sys_time_count #(
        .TIME_W(TIME_W), .WORD_W(WORD_W),
        .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
    ) i_count (
        .clk(clk), .rst(rst),
        .wr_time(wr_en && kind == K_TIME),
        .wr_idx(idx), .wr_data(wr_data), .carry(carry),
        .load(load), .load_val(load_val), .time_q(time_q)
    );

    sys_time_rdpath #(
        .TIME_W(TIME_W), .WORD_W(WORD_W), .ACC_W(ACC_W),
        .NUM_WORDS(NUM_WORDS), .ADD_WORDS(ADD_WORDS), .IDX_W(IDX_W)
    ) i_rdpath (
        .clk(clk), .rst(rst), .rd_en(rd_en),
        .kind(kind), .idx(idx), .time_q(time_q), .addend(addend),
        .rd_low(rd_low), .latch_q(latch_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: rtl/sys_time_counter_chk.sv
module sys_time_counter_chk #(
    parameter int TIME_W = 64,
    parameter int WORD_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_en,
    input logic                     rd_valid,
    input logic                     carry,
    input logic                     load,
    input logic [TIME_W-1:0]        load_val,
    input logic [TIME_W-1:0]        time_q,
    input logic                     rd_low,
    input logic [TIME_W-WORD_W-1:0] latch_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (time_q == '0 && latch_q == '0 && !rd_valid));

    a_r2_hold_no_carry: assert property (@(posedge clk) disable iff (rst)
        (!load && !carry) |=> time_q == $past(time_q));

    a_r2_step_on_carry: assert property (@(posedge clk) disable iff (rst)
        (!load && carry) |=> time_q == $past(time_q) + TIME_W'(1));

    a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> time_q == $past(load_val));

    a_r9_never_down: assert property (@(posedge clk) disable iff (rst)
        !load |=> time_q >= $past(time_q) || $past(time_q) == '1);

    a_r4_latch_capture: assert property (@(posedge clk) disable iff (rst)
        rd_low |=> latch_q == $past(time_q[TIME_W-1:WORD_W]));

    a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_low |=> $stable(latch_q));

    a_r8_valid_on_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

bind sys_time_counter sys_time_counter_chk #(
    .TIME_W(TIME_W), .WORD_W(WORD_W)
) i_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid),
    .carry(carry), .load(load), .load_val(load_val), .time_q(time_q),
    .rd_low(rd_low), .latch_q(latch_q)
);

// File: tb/test_sys_time_counter.sv
`timescale 1ns/1ps
module test_sys_time_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sys_time_counter i_sys_time_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue read, push expected word into the scoreboard
    task automatic bus_read(input logic [3:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_time(input logic [63:0] exp, input string req);
        bus_read(4'h0, exp[15:0], req);
        bus_read(4'h2, exp[31:16], req);
        bus_read(4'h4, exp[47:32], req);
        bus_read(4'h6, exp[63:48], req);
    endtask

    // Monitor: pop and compare each returned word
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R8: unexpected read data actual=%h expected=none", rd_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R8: missing read responses actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_valid", {15'd0, rd_valid}, 16'h0);
        check("R1 rd_data", rd_data, 16'h0);
        rst = 1'b0;

        // R1: everything starts at zero
        read_time(64'h0, "R1 time");
        bus_read(4'h8, 16'h0, "R1 addend lo");
        bus_read(4'hA, 16'h0, "R1 addend hi");

        // R5: staging writes leave the counter alone
        bus_write(4'h0, 16'h1111);
        bus_write(4'h2, 16'h2222);
        bus_write(4'h4, 16'h3333);
        read_time(64'h0, "R5 staged only");

        // R6: top write commits all four words
        bus_write(4'h6, 16'h4444);
        read_time(64'h4444_3333_2222_1111, "R6 load");

        // R4: snapshot survives a reload
        bus_read(4'h0, 16'h1111, "R4 low live");
        bus_write(4'h0, 16'hAAAA);
        bus_write(4'h2, 16'hBBBB);
        bus_write(4'h4, 16'hCCCC);
        bus_write(4'h6, 16'hDDDD);
        bus_read(4'h2, 16'h2222, "R4 latched w1");
        bus_read(4'h4, 16'h3333, "R4 latched w2");
        bus_read(4'h6, 16'h4444, "R4 latched w3");
        read_time(64'hDDDD_CCCC_BBBB_AAAA, "R4 fresh snapshot");

        // R2/R3: addend 0x8000_0000 for 20 edges -> 10 ticks, carry into bit 32
        bus_write(4'h0, 16'hFFF8);
        bus_write(4'h2, 16'hFFFF);
        bus_write(4'h4, 16'h0001);
        bus_write(4'h6, 16'h0000);
        bus_write(4'h8, 16'h0000);
        bus_write(4'hA, 16'h8000);
        repeat (18) @(negedge clk);
        bus_write(4'hA, 16'h0000);
        read_time(64'h0000_0002_0000_0002, "R3 carry across words");
        repeat (10) @(negedge clk);
        read_time(64'h0000_0002_0000_0002, "R2 zero addend holds");

        // R7/R8: addend all ones carries every cycle; load must win
        bus_write(4'h8, 16'hFFFF);
        bus_write(4'hA, 16'hFFFF);
        bus_read(4'h8, 16'hFFFF, "R8 addend lo readback");
        bus_read(4'hA, 16'hFFFF, "R8 addend hi readback");
        bus_write(4'h0, 16'h0005);
        bus_write(4'h2, 16'h0006);
        bus_write(4'h4, 16'h0007);
        bus_write(4'h6, 16'h0008);
        bus_write(4'hA, 16'h0000);
        bus_write(4'h8, 16'h0000);
        read_time(64'h0008_0007_0006_0007, "R7 load beats increment");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule